// File: doc/BRIEF.md
# ULPI Low-Power Entry and Exit Sequencer

This block is the transceiver-side controller that takes an 8-bit synchronous ULPI-style interface into its low-power state and brings it back out. It watches register-write transactions from the link. When the link finishes a write that clears the active-low suspend-control bit of the function control register, the block takes the data bus by raising DIR. It keeps the interface clock running for a fixed number of cycles and then stops it through a clock-run enable. Only that register bit starts the sequence. Activity on the USB line itself never does.

While asleep, the eight data lines are driven by the transceiver and form a status port. The two line-state bits pass straight through from the single-ended receiver inputs. One bit is a combinational interrupt flag. The remaining lines are held low. The link wakes the transceiver by asserting STP. The block then restarts the clock, sets the suspend-control bit back to 1, waits a fixed settling time and releases the bus.

Top module: `ulpi_lpm_seq`

## Requirements
- R1: A register write is a TX command byte with bits [7:6] = 2'b10 and bits [5:0] = the address, then a data byte, then STP. When the address is 0x04 and data bit 6 is 0, dir_o is high and suspendm_o is low in the cycle after the STP cycle.
- R2: A completed write to any other address, or to 0x04 with data bit 6 = 1, leaves dir_o low and clk_run_o high.
- R3: After dir_o rises on entry, clk_run_o stays high for exactly MIN_EDGES cycles with dir_o high (default 5, never fewer), then goes low.
- R4: While the clock is stopped, data_o[0] equals linestate_i[0] and data_o[1] equals linestate_i[1], combinationally.
- R5: While the clock is stopped, data_o[3] is the OR over all sources of irq_src_i & (irq_rise_en_i | irq_fall_en_i).
- R6: While the clock is stopped, data_o[2] and data_o[7:4] are 0 and data_oe_o is 1.
- R7: STP asserted while asleep raises clk_run_o and suspendm_o in the next cycle. dir_o then stays high for exactly STABLE_CYCLES cycles (default 3) before it drops.
- R8: nxt_o is high in the two cycles that follow the cycle in which a register-write command byte is first seen, and only while dir_o is low.
- R9: After reset, dir_o, data_oe_o and nxt_o are 0, and clk_run_o and suspendm_o are 1. data_oe_o always equals dir_o.
- R10: While asleep with STP low, changes on linestate_i or the interrupt inputs do not restart the clock or release the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data bus value driven by the link |
| data_o | output | 8 | Data bus value driven by the transceiver |
| data_oe_o | output | 1 | Output enable for data_o |
| dir_o | output | 1 | Bus direction, 1 = transceiver owns the bus |
| stp_i | input | 1 | Stop strobe from the link |
| nxt_o | output | 1 | Next/throttle strobe to the link |
| linestate_i | input | 2 | Single-ended receiver outputs |
| irq_src_i | input | N_IRQ | Interrupt source levels |
| irq_rise_en_i | input | N_IRQ | Rising-edge interrupt enables |
| irq_fall_en_i | input | N_IRQ | Falling-edge interrupt enables |
| clk_run_o | output | 1 | Interface clock enable, 0 = clock held low |
| suspendm_o | output | 1 | Current value of the suspend-control bit |

## Verification
The bench uses the default parameters: five interrupt sources, a five-cycle minimum run window and a three-cycle wake settling time. These values make the exact lengths of the run window and the wake window countable cycle by cycle. With five interrupt sources, the masking vectors can test rise-only enables, fall-only enables, mismatched enable and source bits, and all sources active with no enable. Every pairing of the four line-state values with the interrupt flag high or low is applied during sleep. Writes that must not trigger entry are issued first, so any false entry shows up on dir_o.

// File: rtl/ulpi_lpm_pkg.sv
package ulpi_lpm_pkg;
  typedef enum logic [1:0] {LP_IDLE, LP_ENTER, LP_SLEEP, LP_WAKE} lp_state_e;
  typedef enum logic [1:0] {SN_IDLE, SN_CMD, SN_DAT, SN_STP} snoop_state_e;
  localparam logic [1:0] TXCMD_REGW = 2'b10;
endpackage

// File: rtl/ulpi_reg_snoop.sv
module ulpi_reg_snoop
  import ulpi_lpm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [7:0]        data_i,
  input  logic              stp_i,
  output logic              nxt_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o
);
  snoop_state_e st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SN_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        SN_IDLE: if (enable_i && data_i[7:6] == TXCMD_REGW) begin
          addr_q <= data_i[ADDR_W-1:0];
          st_q   <= SN_CMD;
        end
        SN_CMD: st_q <= stp_i ? SN_IDLE : SN_DAT;
        SN_DAT: begin
          wdata_q <= data_i;
          st_q    <= stp_i ? SN_IDLE : SN_STP;
        end
        SN_STP: if (stp_i) st_q <= SN_IDLE;
        default: st_q <= SN_IDLE;
      endcase
    end
  end

  assign nxt_o    = (st_q == SN_CMD) || (st_q == SN_DAT);
  assign commit_o = (st_q == SN_STP) && stp_i;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
endmodule

// File: rtl/ulpi_lpm_fsm.sv
module ulpi_lpm_fsm
  import ulpi_lpm_pkg::*;
#(
  parameter int          ADDR_W        = 6,
  parameter int          MIN_EDGES     = 5,
  parameter int          STABLE_CYCLES = 3,
  parameter logic [5:0]  FC_ADDR       = 6'h04,
  parameter int          SUSP_BIT      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              stp_i,
  output logic              dir_o,
  output logic              clk_run_o,
  output logic              sleep_o,
  output logic              suspendm_o,
  output logic              bus_idle_o
);
  localparam int CNT_MAX = (MIN_EDGES > STABLE_CYCLES) ? MIN_EDGES : STABLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  lp_state_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic susp_q;
  logic fc_hit;

  assign fc_hit = commit_i && (addr_i == FC_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LP_IDLE;
      cnt_q  <= '0;
      susp_q <= 1'b1;
    end else begin
      unique case (st_q)
        LP_IDLE: if (fc_hit) begin
          susp_q <= wdata_i[SUSP_BIT];
          cnt_q  <= '0;
          if (!wdata_i[SUSP_BIT]) st_q <= LP_ENTER;
        end
        LP_ENTER: begin
          if (cnt_q == CNT_W'(MIN_EDGES - 1)) begin
            cnt_q <= '0;
            st_q  <= LP_SLEEP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        LP_SLEEP: if (stp_i) begin
          susp_q <= 1'b1;
          cnt_q  <= '0;
          st_q   <= LP_WAKE;
        end
        LP_WAKE: begin
          if (cnt_q == CNT_W'(STABLE_CYCLES - 1)) begin
            cnt_q <= '0;
            st_q  <= LP_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= LP_IDLE;
      endcase
    end
  end

  assign dir_o      = (st_q != LP_IDLE);
  assign clk_run_o  = (st_q != LP_SLEEP);
  assign sleep_o    = (st_q == LP_SLEEP);
  assign suspendm_o = susp_q;
  assign bus_idle_o = (st_q == LP_IDLE);
endmodule

// File: rtl/ulpi_lp_map.sv
module ulpi_lp_map #(
  parameter int N_IRQ = 5
) (
  input  logic             sleep_i,
  input  logic [1:0]       linestate_i,
  input  logic [N_IRQ-1:0] irq_src_i,
  input  logic [N_IRQ-1:0] irq_rise_en_i,
  input  logic [N_IRQ-1:0] irq_fall_en_i,
  output logic [7:0]       data_o
);
  logic [N_IRQ-1:0] masked;
  logic irq;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
    assign masked[i] = irq_src_i[i] & (irq_rise_en_i[i] | irq_fall_en_i[i]);
  end

  assign irq    = |masked;
  assign data_o = sleep_i ? {4'b0000, irq, 1'b0, linestate_i} : 8'h00;
endmodule

// File: rtl/ulpi_lpm_seq.sv
module ulpi_lpm_seq #(
  parameter int         N_IRQ         = 5,
  parameter int         MIN_EDGES     = 5,
  parameter int         STABLE_CYCLES = 3,
  parameter logic [5:0] FC_ADDR       = 6'h04,
  parameter int         SUSP_BIT      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic             dir_o,
  input  logic             stp_i,
  output logic             nxt_o,
  input  logic [1:0]       linestate_i,
  input  logic [N_IRQ-1:0] irq_src_i,
  input  logic [N_IRQ-1:0] irq_rise_en_i,
  input  logic [N_IRQ-1:0] irq_fall_en_i,
  output logic             clk_run_o,
  output logic             suspendm_o
);
  localparam int ADDR_W = 6;

  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              bus_idle;
  logic              sleep;

  ulpi_reg_snoop #(.ADDR_W(ADDR_W)) u_snoop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (bus_idle),
    .data_i   (data_i),
    .stp_i    (stp_i),
    .nxt_o    (nxt_o),
    .commit_o (wr_commit),
    .addr_o   (wr_addr),
    .wdata_o  (wr_data)
  );

  ulpi_lpm_fsm #(
    .ADDR_W        (ADDR_W),
    .MIN_EDGES     (MIN_EDGES),
    .STABLE_CYCLES (STABLE_CYCLES),
    .FC_ADDR       (FC_ADDR),
    .SUSP_BIT      (SUSP_BIT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (wr_commit),
    .addr_i     (wr_addr),
    .wdata_i    (wr_data),
    .stp_i      (stp_i),
    .dir_o      (dir_o),
    .clk_run_o  (clk_run_o),
    .sleep_o    (sleep),
    .suspendm_o (suspendm_o),
    .bus_idle_o (bus_idle)
  );

  ulpi_lp_map #(.N_IRQ(N_IRQ)) u_map (
    .sleep_i       (sleep),
    .linestate_i   (linestate_i),
    .irq_src_i     (irq_src_i),
    .irq_rise_en_i (irq_rise_en_i),
    .irq_fall_en_i (irq_fall_en_i),
    .data_o        (data_o)
  );

  assign data_oe_o = dir_o;
endmodule

// File: rtl/ulpi_lpm_seq_chk.sv
module ulpi_lpm_seq_chk #(
  parameter int         MIN_EDGES = 5,
  parameter logic [5:0] FC_ADDR   = 6'h04,
  parameter int         SUSP_BIT  = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       dir_o,
  input logic       stp_i,
  input logic       nxt_o,
  input logic [1:0] linestate_i,
  input logic       clk_run_o,
  input logic       suspendm_o,
  input logic       wr_commit,
  input logic [5:0] wr_addr,
  input logic [7:0] wr_data
);
  int run_cnt;
  logic enter_wr;

  assign enter_wr = wr_commit && (wr_addr == FC_ADDR) && !wr_data[SUSP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= 0;
    else if (!dir_o) run_cnt <= 0;
    else if (clk_run_o && run_cnt < MIN_EDGES) run_cnt <= run_cnt + 1;
  end

  AST_ENTRY_TAKES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_wr |=> (dir_o && !suspendm_o)); // R1
  AST_NO_FALSE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_commit && !enter_wr) |=> (!dir_o && clk_run_o)); // R2
  AST_MIN_RUN_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_run_o) |-> (run_cnt >= MIN_EDGES)); // R3
  AST_LS_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_run_o |-> (data_o[1:0] == linestate_i)); // R4
  AST_LP_QUIET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_run_o |-> (data_oe_o && !data_o[2] && data_o[7:4] == 4'h0)); // R6
  AST_WAKE_ON_STP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_run_o && stp_i) |=> (clk_run_o && suspendm_o && dir_o)); // R7
  AST_NXT_ONLY_LINK_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_o |-> !dir_o); // R8
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o == dir_o); // R9
  AST_SLEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_run_o && !stp_i) |=> (!clk_run_o && dir_o)); // R10
endmodule

bind ulpi_lpm_seq ulpi_lpm_seq_chk #(
  .MIN_EDGES (MIN_EDGES),
  .FC_ADDR   (FC_ADDR),
  .SUSP_BIT  (SUSP_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .dir_o       (dir_o),
  .stp_i       (stp_i),
  .nxt_o       (nxt_o),
  .linestate_i (linestate_i),
  .clk_run_o   (clk_run_o),
  .suspendm_o  (suspendm_o),
  .wr_commit   (wr_commit),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data)
);

// File: tb/ulpi_lpm_seq_test.sv
module ulpi_lpm_seq_test;
  localparam int N_IRQ = 5;
  localparam int MIN_EDGES = 5;
  localparam int STABLE_CYCLES = 3;
  localparam int NV = 10;

  // {linestate, src, rise_en, fall_en, expected data}
  typedef struct packed {
    logic [1:0]       ls;
    logic [N_IRQ-1:0] src;
    logic [N_IRQ-1:0] ren;
    logic [N_IRQ-1:0] fen;
    logic [7:0]       exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'b00000, 5'b00000, 5'b00000, 8'h00},
    '{2'd1, 5'b00001, 5'b00001, 5'b00000, 8'h09},
    '{2'd2, 5'b00001, 5'b00000, 5'b00000, 8'h02},
    '{2'd3, 5'b10000, 5'b00000, 5'b10000, 8'h0B},
    '{2'd0, 5'b11111, 5'b00000, 5'b00000, 8'h00},
    '{2'd1, 5'b00100, 5'b00010, 5'b01000, 8'h01},
    '{2'd2, 5'b00100, 5'b00100, 5'b00100, 8'h0A},
    '{2'd3, 5'b00000, 5'b11111, 5'b11111, 8'h03},
    '{2'd0, 5'b01000, 5'b00000, 5'b01000, 8'h08},
    '{2'd2, 5'b00010, 5'b00010, 5'b00000, 8'h0A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic data_oe, dir, nxt, clk_run, suspendm;
  logic stp = 1'b0;
  logic [1:0] ls = 2'b00;
  logic [N_IRQ-1:0] src = '0, ren = '0, fen = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ulpi_lpm_seq #(.N_IRQ(N_IRQ), .MIN_EDGES(MIN_EDGES), .STABLE_CYCLES(STABLE_CYCLES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe),
    .dir_o(dir), .stp_i(stp), .nxt_o(nxt), .linestate_i(ls), .irq_src_i(src),
    .irq_rise_en_i(ren), .irq_fall_en_i(fen), .clk_run_o(clk_run), .suspendm_o(suspendm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // full write transaction, inputs changed at negedge
  task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    data_i = {2'b10, a};
    @(negedge clk);
    chk("R8 nxt cycle 1", 32'(nxt), 32'd1);
    @(negedge clk);
    chk("R8 nxt cycle 2", 32'(nxt), 32'd1);
    data_i = d;
    @(negedge clk);
    chk("R8 nxt drops", 32'(nxt), 32'd0);
    data_i = 8'h00;
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 dir reset", 32'(dir), 32'd0);
    chk("R9 oe reset", 32'(data_oe), 32'd0);
    chk("R9 nxt reset", 32'(nxt), 32'd0);
    chk("R9 clk_run reset", 32'(clk_run), 32'd1);
    chk("R9 suspendm reset", 32'(suspendm), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 non-triggering writes
    reg_write(6'h05, 8'h00);
    chk("R2 other addr dir", 32'(dir), 32'd0);
    chk("R2 other addr clk_run", 32'(clk_run), 32'd1);
    reg_write(6'h04, 8'h41);
    chk("R2 bit6 set dir", 32'(dir), 32'd0);
    chk("R2 bit6 set suspendm", 32'(suspendm), 32'd1);

    // R1 entry
    reg_write(6'h04, 8'h01);
    chk("R1 dir after stp", 32'(dir), 32'd1);
    chk("R1 suspendm cleared", 32'(suspendm), 32'd0);
    chk("R9 oe follows dir", 32'(data_oe), 32'd1);

    // R3 run window
    cnt = 0;
    while (clk_run && dir && cnt < 20) begin
      cnt++;
      @(negedge clk);
    end
    chk("R3 run window cycles", 32'(cnt), 32'(MIN_EDGES));
    chk("R3 clock stopped", 32'(clk_run), 32'd0);

    // R4 R5 R6 low-power map
    for (int i = 0; i < NV; i++) begin
      ls = VECS[i].ls; src = VECS[i].src; ren = VECS[i].ren; fen = VECS[i].fen;
      #1;
      chk($sformatf("R4 R5 R6 map vector %0d", i), 32'(data_o), 32'(VECS[i].exp));
      chk("R6 oe in sleep", 32'(data_oe), 32'd1);
      @(negedge clk);
    end

    // R10 inputs toggling do not wake
    for (int i = 0; i < 4; i++) begin
      ls = 2'(i); src = '1; ren = '1;
      @(negedge clk);
    end
    chk("R10 still stopped", 32'(clk_run), 32'd0);
    chk("R10 still owns bus", 32'(dir), 32'd1);
    chk("R4 live linestate", 32'(data_o[1:0]), 32'd3);
    src = '0; ren = '0;

    // R7 wake
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    chk("R7 clk_run restarted", 32'(clk_run), 32'd1);
    chk("R7 suspendm restored", 32'(suspendm), 32'd1);
    cnt = 0;
    while (dir && cnt < 20) begin
      cnt++;
      @(negedge clk);
    end
    chk("R7 settle cycles", 32'(cnt), 32'(STABLE_CYCLES));
    chk("R9 oe after release", 32'(data_oe), 32'd0);

    // R1 second entry after wake
    reg_write(6'h04, 8'h00);
    chk("R1 re-entry dir", 32'(dir), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule